// File: doc/BRIEF.md
# Run-length sample packer

The packer sits between a logic-sample acquisition front end and a byte-wide capture path. It takes one 16-bit sample per accepted cycle and merges consecutive equal samples into runs. Each closed run leaves the block as a three-byte packet: the sample's low byte, then its high byte, then an 8-bit count of how many samples the run held. After every fifth packet the block appends one sequence byte. Each group of five packets plus that byte is a 16-byte unit, and the host always reads whole units.

A single trigger mark closes the open run, so the trigger position always falls on a packet boundary. The block reports how many packets it issued before that boundary. A flush request closes the open run and then fills the current unit with zero-count packets until the unit is complete. The total packet count is therefore always a multiple of five. Samples that change on every cycle cost three bytes each, which is more than their raw two bytes. That is the expected worst case of the scheme.

Top module: `rle_packer`

## Requirements
- R1: After reset, `out_valid_o` is 0, `smp_ready_o` is 1, `trig_seen_o` is 0 and `pretrig_pkts_o` is 0.
- R2: A packet is three bytes in this order: sample bits 7:0, sample bits 15:8, then the run length as an unsigned 8-bit count.
- R3: A run ends when an accepted sample differs from the run's value. A run holds at most 255 samples, and a 256th equal sample starts a new run with count 1.
- R4: After each fifth packet one sequence byte follows. It is 0 in the first unit after reset, increases by one per unit and wraps from 255 to 0.
- R5: An accepted flush (`flush_i` high while the block is idle) emits the open run, if there is one, and then emits packets with value 0 and count 0 until the unit holds five packets. A flush with no open run at a unit boundary emits nothing.
- R6: The first accepted trigger mark (`trig_i` high while `smp_ready_o` is high) closes the open run and sets `trig_seen_o`. `pretrig_pkts_o` then equals the number of packets issued before the mark. Later marks have no effect on the byte stream.
- R7: Before the trigger, `pretrig_pkts_o` counts every packet issued, padding included, and it increases by at most one per cycle. After the trigger it no longer changes.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change.
- R9: `smp_ready_o` is low while a packet is being output, while flush padding is pending, and in any cycle with `flush_i` high. A sample is consumed only when `smp_valid_i` and `smp_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample offered |
| smp_data_i | input | 16 | Sample value |
| smp_ready_o | output | 1 | Sample, mark or flush can be taken |
| trig_i | input | 1 | Trigger mark |
| flush_i | input | 1 | Close run and complete the current unit |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts the byte |
| trig_seen_o | output | 1 | Trigger mark has been taken |
| pretrig_pkts_o | output | PRE_W | Packets issued before the trigger mark |

## Verification
A sweep of run lengths around 1 and around the 255 limit separates a correct count saturation from an off-by-one split or a wrapped count. A stream of samples that changes on every cycle produces more than 256 units, which exposes the sequence-byte wrap and the byte order. Using distinct high and low bytes catches swapped packet bytes. Trigger marks placed inside a run and at a unit boundary, together with a repeated mark, separate a correct pre-trigger count from one that counts too much or keeps counting. Flushes at and off a unit boundary, with irregular downstream stalls, test the padding rule and the output hold.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int unsigned SMP_W = 16;
  localparam int unsigned RUN_W = 8;
  localparam int unsigned PKT_BYTES = (SMP_W + RUN_W) / 8;

  typedef struct packed {
    logic [RUN_W-1:0] cnt;
    logic [SMP_W-1:0] val;
  } pkt_t;
endpackage

// File: rtl/rle_run_acc.sv
module rle_run_acc
  import rle_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic             close_i,
  output logic             emit_o,
  output pkt_t             pkt_o
);
  localparam logic [RUN_W-1:0] CNT_MAX = '1;

  logic [SMP_W-1:0] val_q;
  logic [RUN_W-1:0] cnt_q;
  logic             act_q;
  logic             extend;

  assign extend = act_q && take_i && !close_i && (data_i == val_q) && (cnt_q != CNT_MAX);
  assign emit_o = act_q && ((take_i && !extend) || close_i);
  assign pkt_o  = '{cnt: cnt_q, val: val_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (take_i) begin
      if (extend) begin
        cnt_q <= cnt_q + RUN_W'(1);
      end else begin
        val_q <= data_i;
        cnt_q <= RUN_W'(1);
        act_q <= 1'b1;
      end
    end else if (close_i) begin
      act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rle_unit_ser.sv
module rle_unit_ser
  import rle_pkg::*;
#(
  parameter int unsigned PKTS = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  pkt_t                    pkt_i,
  input  logic                    out_ready_i,
  output logic                    out_valid_o,
  output logic [7:0]              out_data_o,
  output logic                    busy_o,
  output logic [$clog2(PKTS)-1:0] pos_o
);
  localparam int unsigned POS_W = $clog2(PKTS);
  localparam int unsigned PH_W  = $clog2(PKT_BYTES + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PKT_BYTES - 1);
  localparam logic [PH_W-1:0]  PH_SEQ  = PH_W'(PKT_BYTES);
  localparam logic [POS_W-1:0] POS_END = POS_W'(PKTS - 1);

  pkt_t            pkt_q;
  logic            full_q;
  logic            last_q;
  logic [PH_W-1:0] ph_q;
  logic [POS_W-1:0] pos_q;
  logic [7:0]      seq_q;
  logic [7:0]      byte_a [PKT_BYTES+1];
  logic            hs;

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_byte
    assign byte_a[g] = pkt_q[8*g +: 8];
  end
  assign byte_a[PKT_BYTES] = seq_q;

  assign out_valid_o = full_q;
  assign out_data_o  = byte_a[ph_q];
  assign busy_o      = full_q;
  assign pos_o       = pos_q;
  assign hs          = full_q && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
      ph_q   <= '0;
      pos_q  <= '0;
      seq_q  <= '0;
    end else if (load_i) begin
      pkt_q  <= pkt_i;
      full_q <= 1'b1;
      ph_q   <= '0;
      last_q <= (pos_q == POS_END);
      pos_q  <= (pos_q == POS_END) ? '0 : pos_q + POS_W'(1);
    end else if (hs) begin
      if (ph_q == PH_SEQ) begin
        full_q <= 1'b0;
        seq_q  <= seq_q + 8'd1;
      end else if (ph_q == PH_LAST) begin
        if (last_q) ph_q <= PH_SEQ;
        else        full_q <= 1'b0;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/rle_packer.sv
module rle_packer
  import rle_pkg::*;
#(
  parameter int unsigned PKTS_PER_UNIT = 5,
  parameter int unsigned PRE_W         = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [15:0]      smp_data_i,
  output logic             smp_ready_o,
  input  logic             trig_i,
  input  logic             flush_i,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i,
  output logic             trig_seen_o,
  output logic [PRE_W-1:0] pretrig_pkts_o
);
  localparam int unsigned POS_W = $clog2(PKTS_PER_UNIT);

  logic             busy;
  logic [POS_W-1:0] pos;
  logic             pad_q;
  logic             trig_q;
  logic [PRE_W-1:0] pre_q;
  logic             idle, take, flush_acc, trig_acc, close;
  logic             run_emit, pad_load, load;
  pkt_t             run_pkt, ld_pkt;

  assign idle        = !busy && !pad_q;
  assign smp_ready_o = idle && !flush_i;
  assign take        = smp_valid_i && smp_ready_o;
  assign flush_acc   = flush_i && idle;
  assign trig_acc    = trig_i && !trig_q && smp_ready_o;
  assign close       = flush_acc || trig_acc;
  assign pad_load    = pad_q && !busy && (pos != '0);
  assign load        = run_emit || pad_load;
  assign ld_pkt      = run_emit ? run_pkt : '0;

  rle_run_acc u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .data_i  (smp_data_i),
    .close_i (close),
    .emit_o  (run_emit),
    .pkt_o   (run_pkt)
  );

  rle_unit_ser #(.PKTS(PKTS_PER_UNIT)) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .pkt_i       (ld_pkt),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .busy_o      (busy),
    .pos_o       (pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_q  <= 1'b0;
      trig_q <= 1'b0;
      pre_q  <= '0;
    end else begin
      if (flush_acc)                          pad_q <= 1'b1;
      else if (pad_q && !busy && pos == '0)   pad_q <= 1'b0;
      if (trig_acc) trig_q <= 1'b1;
      // a run closed by the mark itself still counts as pre-trigger
      if (load && !trig_q) pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign trig_seen_o    = trig_q;
  assign pretrig_pkts_o = pre_q;
endmodule

// File: rtl/rle_packer_chk.sv
module rle_packer_chk #(
  parameter int unsigned PRE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_ready_o,
  input logic             flush_i,
  input logic             out_valid_o,
  input logic [7:0]       out_data_o,
  input logic             out_ready_i,
  input logic             trig_seen_o,
  input logic [PRE_W-1:0] pretrig_pkts_o
);
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R8
  AST_FLUSH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !smp_ready_o); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !smp_ready_o); // R9
  AST_TRIG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_seen_o |=> trig_seen_o); // R6
  AST_PRE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_seen_o |=> $stable(pretrig_pkts_o)); // R7
  AST_PRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pretrig_pkts_o) |-> pretrig_pkts_o == $past(pretrig_pkts_o) + PRE_W'(1)); // R7
endmodule

bind rle_packer rle_packer_chk #(.PRE_W(PRE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .smp_ready_o    (smp_ready_o),
  .flush_i        (flush_i),
  .out_valid_o    (out_valid_o),
  .out_data_o     (out_data_o),
  .out_ready_i    (out_ready_i),
  .trig_seen_o    (trig_seen_o),
  .pretrig_pkts_o (pretrig_pkts_o)
);

// File: tb/rle_packer_tb.sv
module rle_packer_tb;
  localparam int PKTS  = 5;
  localparam int PRE_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_valid = 1'b0;
  logic [15:0]      smp_data = '0;
  logic             smp_ready;
  logic             trig = 1'b0;
  logic             flush = 1'b0;
  logic             out_valid;
  logic [7:0]       out_data;
  logic             out_ready = 1'b0;
  logic             trig_seen;
  logic [PRE_W-1:0] pretrig;

  always #10 clk = ~clk;

  rle_packer #(.PKTS_PER_UNIT(PKTS), .PRE_W(PRE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .smp_ready_o(smp_ready), .trig_i(trig), .flush_i(flush), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_ready_i(out_ready), .trig_seen_o(trig_seen),
    .pretrig_pkts_o(pretrig)
  );

  int checks = 0;
  int fails = 0;
  int hold_n = 0;
  int hold_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  logic [15:0] m_val;
  int          m_cnt, m_pos, m_pre;
  bit          m_act, m_trig;
  logic [7:0]  m_seq;

  // collector with irregular stalls; also watches the hold rule
  logic [7:0] lfsr = 8'hA7;
  bit         hold_prev = 0;
  logic [7:0] hold_d = '0;
  initial forever begin
    @(negedge clk);
    out_ready = lfsr[0] | lfsr[1];
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #2;
    if (rst_n) begin
      if (hold_prev) begin
        hold_n++;
        if (!(out_valid && out_data == hold_d)) hold_bad++;
      end
      if (out_valid && out_ready) got_q.push_back(out_data);
      hold_prev = out_valid && !out_ready;
      hold_d = out_data;
    end else hold_prev = 0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    int bad = -1;
    checks++;
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (bad < 0 && exp_q[i] != got_q[i]) bad = i;
    if (bad >= 0 || exp_q.size() != got_q.size()) begin
      fails++;
      if (bad >= 0)
        $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, bad, got_q[bad], exp_q[bad]);
      else
        $display("FAIL %s length actual=%0d expected=%0d", tag, got_q.size(), exp_q.size());
    end
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic m_emit(input logic [15:0] v, input int c);
    exp_q.push_back(v[7:0]);
    exp_q.push_back(v[15:8]);
    exp_q.push_back(c[7:0]);
    m_pos++;
    if (!m_trig) m_pre++;
    if (m_pos == PKTS) begin
      exp_q.push_back(m_seq);
      m_seq++;
      m_pos = 0;
    end
  endtask

  task automatic wait_ready();
    #1;
    while (!smp_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data = v;
    wait_ready();
    @(posedge clk);
    if (m_act && v == m_val && m_cnt < 255) m_cnt++;
    else begin
      if (m_act) m_emit(m_val, m_cnt);
      m_val = v;
      m_cnt = 1;
      m_act = 1;
    end
    #1 smp_valid = 1'b0;
  endtask

  task automatic mark();
    @(negedge clk);
    trig = 1'b1;
    wait_ready();
    @(posedge clk);
    if (!m_trig) begin
      if (m_act) m_emit(m_val, m_cnt);
      m_act = 0;
      m_trig = 1;
    end
    #1 trig = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    wait_ready();
    flush = 1'b1;
    @(posedge clk);
    if (m_act) m_emit(m_val, m_cnt);
    m_act = 0;
    while (m_pos != 0) m_emit(16'h0, 0);
    #1 flush = 1'b0;
  endtask

  task automatic drain();
    repeat (100) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_act = 0; m_trig = 0; m_cnt = 0; m_pos = 0; m_pre = 0; m_seq = 8'd0; m_val = '0;
    exp_q.delete();
    got_q.delete();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lens[13] = '{1, 2, 3, 4, 5, 6, 7, 254, 255, 256, 257, 511, 512};
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(smp_ready == 1'b1, "R1 smp_ready", smp_ready, 1);
    chk(trig_seen == 1'b0, "R1 trig_seen", trig_seen, 0);
    chk(pretrig == '0, "R1 pretrig", pretrig, 0);

    // R2 R3: run lengths around 1 and around the 255 limit
    foreach (lens[k]) begin
      for (int n = 0; n < lens[k]; n++) push(16'h1234 + 16'(k) * 16'h0111);
    end
    do_flush();
    drain();
    chk(pretrig == PRE_W'(m_pre), "R7 count without trigger", pretrig, m_pre);
    chk(trig_seen == 1'b0, "R6 no mark no trigger", trig_seen, 0);
    cmp("R2 R3 run length sweep");
    do_flush();
    drain();
    chk(got_q.size() == 0, "R5 flush at boundary is silent", got_q.size(), 0);

    // R4: changing every sample, more than 256 units
    do_reset();
    for (int i = 0; i < 1300; i++) push({8'(i), 8'(i >> 8)});
    do_flush();
    drain();
    chk(pretrig == 1300, "R7 packet count", pretrig, 1300);
    cmp("R4 R2 sequence wrap stream");

    // R6 R7: mark inside a run, then a repeated mark
    do_reset();
    repeat (3) push(16'hA1B2);
    repeat (2) push(16'hC3D4);
    push(16'hE5F6);
    mark();
    drain();
    chk(trig_seen == 1'b1, "R6 trig_seen", trig_seen, 1);
    chk(pretrig == 3, "R6 pretrig after mark", pretrig, 3);
    repeat (2) push(16'hA1B2);
    mark();
    repeat (2) push(16'hA1B2);
    push(16'h0F0F);
    do_flush();
    drain();
    chk(pretrig == 3, "R7 frozen after mark", pretrig, 3);
    cmp("R6 R5 stream with repeated mark");

    // R6: mark at a unit boundary with no open run
    do_reset();
    for (int i = 0; i < 5; i++) push(16'h0100 + 16'(i));
    do_flush();
    mark();
    push(16'h7777);
    do_flush();
    drain();
    chk(pretrig == 5, "R6 mark on boundary", pretrig, 5);
    cmp("R6 R5 boundary mark stream");

    // R9: flush blocks a simultaneous sample
    do_reset();
    @(negedge clk);
    flush = 1'b1;
    smp_valid = 1'b1;
    smp_data = 16'h5555;
    #1;
    chk(smp_ready == 1'b0, "R9 ready low with flush", smp_ready, 0);
    @(posedge clk);
    #1;
    flush = 1'b0;
    smp_valid = 1'b0;
    drain();
    chk(got_q.size() == 0, "R9 sample not taken under flush", got_q.size(), 0);
    push(16'h9ABC);
    do_flush();
    drain();
    cmp("R5 padding of single packet");

    chk(hold_bad == 0 && hold_n > 0, "R8 output hold under stall", hold_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule